// File: doc/BRIEF.md
# Phase-0 Serial Master with Framed Select Timing

This block is a serial master that moves one word out on a data-out line and captures one word from a data-in line. It uses clock phase 0. The first outgoing bit is already on the data-out line when the active-low select goes low. Each transition of the serial clock away from its idle level is a sampling instant. The outgoing data changes only on the opposite transition, half a serial period later. A polarity input sets the idle level of the serial clock. It has no effect on when sampling or data changes happen.

A transfer is framed by three programmable intervals, all counted in whole serial clock periods. The lead interval runs from select assertion to the first clock transition. The lag interval runs from the last clock transition to select negation. The gap interval follows select negation, and the block holds off the next select assertion until it has expired. The divider count, the three interval counts and the transmit word are latched when a start request is accepted. The received word is presented together with a one-cycle completion strobe.

Top module: `spi_frame_master`

## Requirements
- R1: After reset, and whenever no transfer runs: `ss_n` is 1, `sclk` equals `cpol`, `mosi` is 0, `busy` is 0 and `done` is 0.
- R2: A start accepted at a clock edge makes `ss_n` 0 and `busy` 1 in the next cycle, with `mosi` equal to bit WORD_W-1 of the transmit word. MSB goes first.
- R3: Each serial clock half period lasts H system clocks. H = `div_cnt`, and a value of 0 is treated as 1.
- R4: From the cycle `ss_n` falls to the first `sclk` transition there are 2*H*max(`lead_dly`,1) system clocks.
- R5: The block samples `miso` on the WORD_W leading (away-from-idle) `sclk` transitions, MSB first, and the result appears on `rx_word`.
- R6: `mosi` moves to the next lower bit only on trailing (back-to-idle) `sclk` transitions. It does not move after the last one.
- R7: From the last `sclk` transition to `ss_n` rising there are 2*H*max(`lag_dly`,1) system clocks.
- R8: `done` is high for exactly one cycle, the cycle in which `ss_n` first reads 1. `rx_word` holds the captured word from then until the next completion.
- R9: `busy` stays 1 for 2*H*max(`gap_dly`,1) system clocks after `ss_n` rises, and `ss_n` stays high throughout. A start is accepted only while `busy` is 0.
- R10: While `busy` is 1, `start` and `tx_word` have no effect on the running transfer or on the following gap.
- R11: With `cpol` = 1, the `sclk` waveform is the inverse of the `cpol` = 0 waveform, with identical transition cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Transfer request, honoured when idle |
| tx_word | input | WORD_W | Word to transmit, latched on acceptance |
| cpol | input | 1 | Serial clock idle level |
| div_cnt | input | DIV_W | System clocks per serial half period (0 acts as 1) |
| lead_dly | input | DLY_W | Select-to-clock interval in serial periods (0 acts as 1) |
| lag_dly | input | DLY_W | Clock-to-deselect interval in serial periods (0 acts as 1) |
| gap_dly | input | DLY_W | Idle interval before next select in serial periods (0 acts as 1) |
| miso | input | 1 | Serial data in |
| sclk | output | 1 | Serial clock |
| ss_n | output | 1 | Active-low select |
| mosi | output | 1 | Serial data out |
| rx_word | output | WORD_W | Last received word |
| done | output | 1 | One-cycle completion strobe |
| busy | output | 1 | Transfer or gap in progress |

## Verification
The hardest case to reach from the ports is a request that is still pending when the gap interval ends. The block must hold it off through the whole gap and then accept it on the first idle cycle. At the same time, a transmit word that changed during the busy period must be ignored. The stimulus holds `start` high across a transfer and changes `tx_word` in mid-flight. Other runs use zero-valued divider and delay settings, so the minimum clamps take effect and back-to-back transitions happen every system clock.

// File: rtl/spi_fm_pkg.sv
// Shared definitions for the phase-0 serial master.
// Assumes nothing beyond IEEE 1800-2017 enum support.
package spi_fm_pkg;

    // Sequencer phases of one framed transfer
    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_LEAD  = 3'd1,
        ST_SHIFT = 3'd2,
        ST_LAG   = 3'd3,
        ST_GAP   = 3'd4
    } fm_state_t;

endpackage

// File: rtl/spi_fm_tick.sv
// Half-period tick generator.
// Emits a one-cycle tick every half_len system clocks while run is high,
// and restarts from zero whenever run is low. Assumes half_len >= 1.
module spi_fm_tick #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] half_len,
    output logic             tick
);

    logic [DIV_W-1:0] cnt_q;

    assign tick = run && (cnt_q == (half_len - 1'b1));

    // Count system clocks within the current half period
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (!run || tick)
            cnt_q <= '0;
        else
            cnt_q <= cnt_q + 1'b1;
    end

endmodule

// File: rtl/spi_fm_seq.sv
// Transfer sequencer: lead, shift, lag and gap phases.
// Latches the divider and delay settings on an accepted start. It drives
// select, the clock phase, the strobes for the data path, done and busy.
// Assumes tick comes from spi_fm_tick driven by this block's run/half_len.
module spi_fm_seq
    import spi_fm_pkg::*;
#(
    parameter int WORD_W = 8,
    parameter int DIV_W  = 8,
    parameter int DLY_W  = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [DIV_W-1:0] div_cnt,
    input  logic [DLY_W-1:0] lead_dly,
    input  logic [DLY_W-1:0] lag_dly,
    input  logic [DLY_W-1:0] gap_dly,
    input  logic             tick,
    output logic             run,
    output logic [DIV_W-1:0] half_len,
    output logic             load,
    output logic             sample,
    output logic             shift,
    output logic             commit,
    output logic             ss_n,
    output logic             phase,
    output logic             done,
    output logic             busy
);

    localparam int EDGES  = 2 * WORD_W;
    localparam int EDGE_W = $clog2(EDGES) + 1;
    localparam int CNT_W  = (DLY_W + 1 > EDGE_W) ? DLY_W + 1 : EDGE_W;
    localparam logic [CNT_W-1:0] LAST_EDGE = CNT_W'(EDGES - 1);
    localparam logic [CNT_W-1:0] ONE       = CNT_W'(1);

    fm_state_t        state_q;
    logic [CNT_W-1:0] remain_q;
    logic [DLY_W-1:0] lag_q;
    logic [DLY_W-1:0] gap_q;
    logic [DIV_W-1:0] div_q;
    logic             ss_n_q;
    logic             phase_q;
    logic             done_q;
    logic             accept;

    // Number of half periods for a delay setting, with a floor of one period
    function automatic logic [CNT_W-1:0] halves(input logic [DLY_W-1:0] v);
        if (v == '0)
            return CNT_W'(2);
        else
            return CNT_W'({v, 1'b0});
    endfunction

    assign accept   = start && (state_q == ST_IDLE);
    assign run      = (state_q != ST_IDLE);
    assign busy     = run;
    assign half_len = div_q;
    assign load     = accept;
    assign ss_n     = ss_n_q;
    assign phase    = phase_q;
    assign done     = done_q;
    assign sample   = tick && (state_q == ST_SHIFT) && !phase_q;
    assign shift    = tick && (state_q == ST_SHIFT) && phase_q && (remain_q != LAST_EDGE);
    assign commit   = tick && (state_q == ST_LAG) && (remain_q == ONE);

    // Phase sequencing and the interval/edge counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            remain_q <= '0;
            lag_q    <= '0;
            gap_q    <= '0;
            div_q    <= DIV_W'(1);
            ss_n_q   <= 1'b1;
            phase_q  <= 1'b0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (accept) begin
                        state_q  <= ST_LEAD;
                        remain_q <= halves(lead_dly) - ONE;
                        lag_q    <= lag_dly;
                        gap_q    <= gap_dly;
                        div_q    <= (div_cnt == '0) ? DIV_W'(1) : div_cnt;
                        ss_n_q   <= 1'b0;
                        phase_q  <= 1'b0;
                    end
                end
                ST_LEAD: begin
                    if (tick) begin
                        if (remain_q == ONE) begin
                            state_q  <= ST_SHIFT;
                            remain_q <= '0;
                        end else begin
                            remain_q <= remain_q - ONE;
                        end
                    end
                end
                ST_SHIFT: begin
                    if (tick) begin
                        phase_q <= ~phase_q;
                        if (remain_q == LAST_EDGE) begin
                            state_q  <= ST_LAG;
                            remain_q <= halves(lag_q);
                        end else begin
                            remain_q <= remain_q + ONE;
                        end
                    end
                end
                ST_LAG: begin
                    if (tick) begin
                        if (remain_q == ONE) begin
                            state_q  <= ST_GAP;
                            remain_q <= halves(gap_q);
                            ss_n_q   <= 1'b1;
                        end else begin
                            remain_q <= remain_q - ONE;
                        end
                    end
                end
                ST_GAP: begin
                    if (tick) begin
                        if (remain_q == ONE)
                            state_q <= ST_IDLE;
                        else
                            remain_q <= remain_q - ONE;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // One-cycle completion strobe aligned with select negation
    always_ff @(posedge clk) begin
        if (!rst_n)
            done_q <= 1'b0;
        else
            done_q <= commit;
    end

endmodule

// File: rtl/spi_fm_shift.sv
// Transmit and receive shift registers.
// Loads the transmit word on load, shifts it MSB first on shift, captures
// miso on sample, and publishes the received word on commit.
// Assumes strobes come from spi_fm_seq; mosi is forced low when deselected.
module spi_fm_shift #(
    parameter int WORD_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [WORD_W-1:0] tx_word,
    input  logic              shift,
    input  logic              sample,
    input  logic              commit,
    input  logic              ss_n,
    input  logic              miso,
    output logic              mosi,
    output logic [WORD_W-1:0] rx_word
);

    logic [WORD_W-1:0] tx_sr;
    logic [WORD_W-1:0] rx_sr;
    logic [WORD_W-1:0] rx_q;

    assign mosi    = !ss_n && tx_sr[WORD_W-1];
    assign rx_word = rx_q;

    // Transmit register: load on accept, move toward MSB on trailing edges
    always_ff @(posedge clk) begin
        if (!rst_n)
            tx_sr <= '0;
        else if (load)
            tx_sr <= tx_word;
        else if (shift)
            tx_sr <= {tx_sr[WORD_W-2:0], 1'b0};
    end

    // Receive register: take miso on leading edges
    always_ff @(posedge clk) begin
        if (!rst_n)
            rx_sr <= '0;
        else if (sample)
            rx_sr <= {rx_sr[WORD_W-2:0], miso};
    end

    // Published receive word, updated at select negation
    always_ff @(posedge clk) begin
        if (!rst_n)
            rx_q <= '0;
        else if (commit)
            rx_q <= rx_sr;
    end

endmodule

// File: rtl/spi_frame_master.sv
// Phase-0 serial master with programmable lead, lag and gap intervals.
// Connects the sequencer, half-period tick generator and shift registers.
// Assumes cpol is held steady while busy.
module spi_frame_master #(
    parameter int WORD_W = 8,
    parameter int DIV_W  = 8,
    parameter int DLY_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [WORD_W-1:0] tx_word,
    input  logic              cpol,
    input  logic [DIV_W-1:0]  div_cnt,
    input  logic [DLY_W-1:0]  lead_dly,
    input  logic [DLY_W-1:0]  lag_dly,
    input  logic [DLY_W-1:0]  gap_dly,
    input  logic              miso,
    output logic              sclk,
    output logic              ss_n,
    output logic              mosi,
    output logic [WORD_W-1:0] rx_word,
    output logic              done,
    output logic              busy
);

    logic             run;
    logic             tick;
    logic [DIV_W-1:0] half_len;
    logic             load;
    logic             sample;
    logic             shift;
    logic             commit;
    logic             phase;

    assign sclk = cpol ^ phase;

    spi_fm_tick #(.DIV_W(DIV_W)) u_tick (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (run),
        .half_len (half_len),
        .tick     (tick)
    );

    spi_fm_seq #(.WORD_W(WORD_W), .DIV_W(DIV_W), .DLY_W(DLY_W)) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .div_cnt  (div_cnt),
        .lead_dly (lead_dly),
        .lag_dly  (lag_dly),
        .gap_dly  (gap_dly),
        .tick     (tick),
        .run      (run),
        .half_len (half_len),
        .load     (load),
        .sample   (sample),
        .shift    (shift),
        .commit   (commit),
        .ss_n     (ss_n),
        .phase    (phase),
        .done     (done),
        .busy     (busy)
    );

    spi_fm_shift #(.WORD_W(WORD_W)) u_shift (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (load),
        .tx_word (tx_word),
        .shift   (shift),
        .sample  (sample),
        .commit  (commit),
        .ss_n    (ss_n),
        .miso    (miso),
        .mosi    (mosi),
        .rx_word (rx_word)
    );

endmodule

// File: rtl/spi_fm_checker.sv
// Port-level protocol checker for spi_frame_master, attached by bind.
// Assumes cpol changes only while the block is idle.
module spi_fm_checker (
    input logic clk,
    input logic rst_n,
    input logic start,
    input logic cpol,
    input logic sclk,
    input logic ss_n,
    input logic mosi,
    input logic done,
    input logic busy
);

    // Deselected means the serial clock sits at its idle level
    assert_idle_level_R1: assert property (@(posedge clk) disable iff (!rst_n)
        ss_n |-> (sclk == cpol));

    // An accepted start selects the target in the following cycle
    assert_accept_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> (busy && !ss_n));

    // Data out holds still across a leading clock transition
    assert_mosi_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!ss_n && !$past(ss_n) && ($past(sclk) == cpol) && (sclk != cpol)) |-> $stable(mosi));

    // Completion coincides with select negation
    assert_done_at_negate_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $rose(ss_n));

    // Completion lasts one cycle
    assert_done_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // Select may be low only while busy
    assert_select_in_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> ss_n);

    // A request during busy does not end the busy period early
    assert_busy_request_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (start && busy && !ss_n) |=> busy);

endmodule

bind spi_frame_master spi_fm_checker u_fm_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .start (start),
    .cpol  (cpol),
    .sclk  (sclk),
    .ss_n  (ss_n),
    .mosi  (mosi),
    .done  (done),
    .busy  (busy)
);

// File: tb/spi_frame_master_test.sv
`timescale 1ns/1ps
module spi_frame_master_test;

    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic [W-1:0] tx_word = '0;
    logic         cpol = 1'b0;
    logic [7:0]   div_cnt = 8'd1;
    logic [3:0]   lead_dly = 4'd1;
    logic [3:0]   lag_dly = 4'd1;
    logic [3:0]   gap_dly = 4'd1;
    logic         miso = 1'b0;
    logic         sclk, ss_n, mosi, done, busy;
    logic [W-1:0] rx_word;

    integer total_checks = 0;
    integer bad_checks = 0;
    integer cyc = 0;
    bit     finished = 0;

    // Reference model state
    bit           m_active = 0;
    bit           m_live = 0;
    integer       m_n, m_d, m_l, m_lg, m_g, m_tneg, m_total;
    logic [W-1:0] m_tx;
    logic [W-1:0] rx_pat = '0;
    logic [W-1:0] m_rx;

    // Bench-side target model
    logic [W-1:0] slv;
    bit           slv_loaded = 0;
    logic         slv_prev = 1'b0;

    spi_frame_master uut (
        .clk(clk), .rst_n(rst_n), .start(start), .tx_word(tx_word), .cpol(cpol),
        .div_cnt(div_cnt), .lead_dly(lead_dly), .lag_dly(lag_dly), .gap_dly(gap_dly),
        .miso(miso), .sclk(sclk), .ss_n(ss_n), .mosi(mosi), .rx_word(rx_word),
        .done(done), .busy(busy)
    );

    always #4 clk = ~clk;

    function automatic integer at_least1(input integer v);
        return (v == 0) ? 1 : v;
    endfunction

    task automatic chk(input bit ok, input string tag, input string what,
                       input integer act, input integer exp);
        total_checks++;
        if (!ok) begin
            bad_checks++;
            $display("FAIL %s %s at cycle %0d: actual=%0h expected=%0h", tag, what, cyc, act, exp);
        end
    endtask

    // Model advance at each edge: accept only when idle
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (!rst_n) begin
            m_active = 0;
        end else if (!m_active) begin
            if (start) begin
                m_active = 1;
                m_n = 0;
                m_d = at_least1(div_cnt);
                m_l = at_least1(lead_dly);
                m_lg = at_least1(lag_dly);
                m_g = at_least1(gap_dly);
                m_tx = tx_word;
                m_rx = rx_pat;
                m_tneg = 2*m_l + 2*W - 1 + 2*m_lg;
                m_total = (m_tneg + 2*m_g) * m_d;
            end
        end else begin
            m_n = m_n + 1;
            if (m_n == m_total) m_active = 0;
        end
    end

    // Per-cycle comparison against the model
    always @(negedge clk) begin
        if (rst_n && m_live) begin
            integer h, edges, shifts;
            logic e_ss, e_sclk, e_mosi, e_busy, e_done;
            if (m_active) begin
                h = m_n / m_d;
                edges = h - (2*m_l - 1);
                if (edges < 0) edges = 0;
                if (edges > 2*W) edges = 2*W;
                shifts = edges / 2;
                if (shifts > W-1) shifts = W-1;
                e_ss = (h >= m_tneg);
                e_sclk = cpol ^ edges[0];
                e_mosi = e_ss ? 1'b0 : m_tx[W-1-shifts];
                e_busy = 1'b1;
                e_done = (h == m_tneg) && (m_n % m_d == 0);
            end else begin
                e_ss = 1'b1; e_sclk = cpol; e_mosi = 1'b0; e_busy = 1'b0; e_done = 1'b0;
            end
            chk(ss_n == e_ss, "R2 R4 R7", "ss_n", ss_n, e_ss);
            chk(sclk == e_sclk, "R3 R4 R11", "sclk", sclk, e_sclk);
            chk(mosi == e_mosi, "R2 R6 R10", "mosi", mosi, e_mosi);
            chk(busy == e_busy, "R9 R10", "busy", busy, e_busy);
            chk(done == e_done, "R8", "done", done, e_done);
            if (e_done)
                chk(rx_word == m_rx, "R5 R8", "rx_word", rx_word, m_rx);
        end
    end

    // Target: present MSB on select, advance on trailing clock transitions
    always @(negedge clk) begin
        if (ss_n) begin
            slv_loaded = 0;
        end else if (!slv_loaded) begin
            slv = rx_pat;
            slv_loaded = 1;
        end else if ((sclk != slv_prev) && (sclk == cpol)) begin
            slv = {slv[W-2:0], 1'b0};
        end
        slv_prev = sclk;
        miso = slv_loaded ? slv[W-1] : 1'b0;
    end

    task automatic run_xfer(input logic [W-1:0] tx, input logic [W-1:0] rxp,
                            input logic [7:0] d, input logic [3:0] l,
                            input logic [3:0] lg, input logic [3:0] g, input logic pol);
        @(negedge clk); #1;
        cpol = pol; div_cnt = d; lead_dly = l; lag_dly = lg; gap_dly = g;
        tx_word = tx; rx_pat = rxp; start = 1'b1;
        @(negedge clk); #1;
        start = 1'b0;
        while (m_active) @(negedge clk);
        @(negedge clk);
    endtask

    // Watchdog
    always @(posedge clk) begin
        if (cyc > 150000 && !finished) begin
            finished = 1;
            bad_checks++;
            total_checks++;
            $display("FAIL watchdog expired at cycle %0d: actual=hung expected=finished", cyc);
            $display("  test done: total=%0d bad=%0d", total_checks, bad_checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        // R1: idle outputs after reset
        chk(ss_n == 1'b1, "R1", "ss_n", ss_n, 1);
        chk(sclk == 1'b0, "R1", "sclk", sclk, 0);
        chk(mosi == 1'b0, "R1", "mosi", mosi, 0);
        chk(busy == 1'b0, "R1", "busy", busy, 0);
        chk(done == 1'b0, "R1", "done", done, 0);
        m_live = 1;

        // R3 R4 R5: basic transfer
        run_xfer(8'hA5, 8'h3C, 8'd2, 4'd1, 4'd1, 4'd1, 1'b0);
        chk(rx_word == 8'h3C, "R5", "rx_word held", rx_word, 8'h3C);
        // R3: zero divider and zero delays clamp to one
        run_xfer(8'h81, 8'h7E, 8'd0, 4'd0, 4'd0, 4'd0, 1'b0);
        // R11: inverted polarity with longer intervals
        run_xfer(8'hC3, 8'h96, 8'd3, 4'd3, 4'd2, 4'd4, 1'b1);
        chk(sclk == 1'b1, "R11", "idle sclk", sclk, 1);
        // R7 R9: long lag and gap
        run_xfer(8'h5A, 8'hF0, 8'd1, 4'd2, 4'd5, 4'd6, 1'b0);

        // R10: start held through busy, tx_word altered in flight
        @(negedge clk); #1;
        div_cnt = 8'd2; lead_dly = 4'd1; lag_dly = 4'd1; gap_dly = 4'd3;
        tx_word = 8'h69; rx_pat = 8'hA3; start = 1'b1;
        repeat (20) @(negedge clk);
        #1 tx_word = 8'h0F;
        chk(busy == 1'b1, "R10", "busy mid-transfer", busy, 1);
        while (m_active) @(negedge clk);
        // Second transfer starts as soon as the gap ends, with 8'h0F
        @(negedge clk);
        chk(ss_n == 1'b0, "R9 R10", "pending start accepted", ss_n, 0);
        #1 start = 1'b0;
        while (m_active) @(negedge clk);
        chk(rx_word == 8'hA3, "R5 R8", "rx_word after second", rx_word, 8'hA3);
        repeat (3) @(negedge clk);
        chk(ss_n == 1'b1 && busy == 1'b0, "R1", "idle at end", {ss_n, busy}, 2);

        finished = 1;
        $display("  test done: total=%0d bad=%0d", total_checks, bad_checks);
        $finish;
    end

endmodule